// File: doc/BRIEF.md
# Indexed Clock-Channel Configuration Register

This block keeps the settings of several master clock channels behind one 32-bit control word. Each channel has an enable, a 5-bit source select and a 3-bit prescaler code. The block drives these settings to a clock path outside it, and that path returns a one-cycle done pulse when a source switch has finished.

Software reaches the channels through a single window. A write with the command flag clear only points the window at a channel, so that the next read of the control word shows that channel's stored settings. A write with the command flag set commits new settings to the channel it names. When a commit moves a channel to a different source, the channel's readiness drops and stays low until the clock path reports that the switch is done. Channel 0 reports readiness on its own status bit. All other channels share one combined bit.

Reads are combinational from the address. Writes take effect at the clock edge on which `bus_wen` is high.

Top module: `clkchan_regbank`

## Requirements
- R1: After reset every channel has enable 0, source 0 and prescaler 0, the latched index is 0, and both ready bits are 1.
- R2: A write to the control word (offset 0x30) with bit 7 clear latches the index from bits [3:0] and changes no channel setting. A control read returns the selected channel's enable in bit 28, source in bits [20:16], prescaler in bits [10:8] and the index in bits [3:0]. Bit 7 and all other bits read 0.
- R3: A control write with bit 7 set and bit 28 set loads the addressed channel's source and prescaler from bits [20:16] and [10:8] and sets its enable. It also latches the index. No other channel changes.
- R4: A control write with bit 7 set and bit 28 clear clears only the addressed channel's enable. Its source and prescaler keep their values.
- R5: A commit that changes a channel's source makes that channel's ready bit 0 from the next cycle. The bit stays 0 until a `sw_done` pulse for that channel, and is 1 in the cycle after the pulse.
- R6: A commit that keeps the current source, or that disables the channel, leaves readiness unchanged.
- R7: The status word (offset 0x34) carries channel 0 ready in bit 0 and the AND of the ready states of channels 1 and up in bit 1. Its other bits read 0. The same two values appear on `rdy_ch0` and `rdy_rest`.
- R8: A commit that names an index of NCH or above changes no channel. A select write may latch such an index, and the control read then returns zero fields together with that index.
- R9: Writes to any other offset, or with `bus_wen` low, have no effect. Reads of unmapped offsets return 0.
- R10: When a source-changing commit and a done pulse for the same channel fall in the same cycle, the channel stays not ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wen | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte offset for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| sw_done | input | NCH | One-cycle pulse per channel when its source switch has finished |
| ch_en | output | NCH | Per-channel enable |
| ch_src | output | NCH*5 | Per-channel source select, channel i at bits [5i+4:5i] |
| ch_pres | output | NCH*3 | Per-channel prescaler code, channel i at bits [3i+2:3i] |
| rdy_ch0 | output | 1 | Channel 0 has no switch pending |
| rdy_rest | output | 1 | No channel above 0 has a switch pending |

## Verification
The bench checks a commit that keeps the current source. A design that armed the pending flag on every commit would drop ready there. It checks a disable that carries a zero source field. A design that loaded every field would move the source and prescaler to 0. It commits to index 6 and then reads channel 2 back, which catches a design that wraps or truncates the index and so corrupts a real channel. It drives a done pulse in the same cycle as a new switch and a done pulse for one channel in the same cycle as a switch on another channel. A design that let done win, or that cleared the wrong flag, would report ready too early.

// File: rtl/clkchan_regbank.sv
module clkchan_regbank #(
  parameter int NCH = 5,
  parameter logic [7:0] CTRL_OFS = 8'h30,
  parameter logic [7:0] STAT_OFS = 8'h34
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wen,
  input  logic [7:0]           bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NCH-1:0]       sw_done,
  output logic [NCH-1:0]       ch_en,
  output logic [NCH*5-1:0]     ch_src,
  output logic [NCH*3-1:0]     ch_pres,
  output logic                 rdy_ch0,
  output logic                 rdy_rest
);
  localparam int SRCW = 5;
  localparam int PRESW = 3;
  localparam int IDXW = 4;

  logic [IDXW-1:0]  idx_q;
  logic [NCH-1:0]   pend_q;
  logic [SRCW-1:0]  src_q  [NCH];
  logic [PRESW-1:0] pres_q [NCH];

  wire              wr_ctrl = bus_wen && (bus_addr == CTRL_OFS);
  wire              w_cmd   = bus_wdata[7];
  wire [IDXW-1:0]   w_idx   = bus_wdata[3:0];
  wire [PRESW-1:0]  w_pres  = bus_wdata[10:8];
  wire [SRCW-1:0]   w_src   = bus_wdata[20:16];
  wire              w_en    = bus_wdata[28];
  wire              idx_ok  = int'(w_idx) < NCH;
  wire              commit  = wr_ctrl && w_cmd && idx_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) idx_q <= '0;
    else if (wr_ctrl) idx_q <= w_idx;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    wire hit = commit && (w_idx == IDXW'(i));
    wire arm = hit && w_en && (w_src != src_q[i]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ch_en[i]  <= 1'b0;
        src_q[i]  <= '0;
        pres_q[i] <= '0;
        pend_q[i] <= 1'b0;
      end else begin
        if (hit) begin
          ch_en[i] <= w_en;
          if (w_en) begin
            src_q[i]  <= w_src;
            pres_q[i] <= w_pres;
          end
        end
        if (arm) pend_q[i] <= 1'b1;
        else if (sw_done[i]) pend_q[i] <= 1'b0;
      end
    end

    assign ch_src[i*SRCW +: SRCW]    = src_q[i];
    assign ch_pres[i*PRESW +: PRESW] = pres_q[i];

    AST_SWITCH_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && w_en && (w_src != ch_src[i*SRCW +: SRCW])) |=> ((i == 0) ? !rdy_ch0 : !rdy_rest)); // R5
  end

  assign rdy_ch0  = !pend_q[0];
  assign rdy_rest = !(|pend_q[NCH-1:1]);

  logic             f_en;
  logic [SRCW-1:0]  f_src;
  logic [PRESW-1:0] f_pres;

  always_comb begin
    f_en = 1'b0;
    f_src = '0;
    f_pres = '0;
    for (int i = 0; i < NCH; i++) begin
      if (idx_q == IDXW'(i)) begin
        f_en = ch_en[i];
        f_src = src_q[i];
        f_pres = pres_q[i];
      end
    end
  end

  always_comb begin
    if (bus_addr == CTRL_OFS)
      bus_rdata = {3'b0, f_en, 7'b0, f_src, 5'b0, f_pres, 4'b0, idx_q};
    else if (bus_addr == STAT_OFS)
      bus_rdata = {30'b0, rdy_rest, rdy_ch0};
    else
      bus_rdata = '0;
  end

  AST_SELECT_KEEPS_SETTINGS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !w_cmd) |=> ($stable(ch_en) && $stable(ch_src) && $stable(ch_pres))); // R2
  AST_DISABLE_KEEPS_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !w_en) |=> ($stable(ch_src) && $stable(ch_pres))); // R4
  AST_BAD_INDEX_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && w_cmd && !idx_ok) |=> ($stable(ch_en) && $stable(ch_src) && $stable(ch_pres))); // R8
  AST_PENDING_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy_ch0 && !sw_done[0]) |=> !rdy_ch0); // R5
  AST_STATUS_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == STAT_OFS) |-> (bus_rdata[31:2] == 30'b0)); // R7
  AST_FOREIGN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wen || (bus_addr != CTRL_OFS)) |=> ($stable(ch_en) && $stable(ch_src) && $stable(ch_pres))); // R9
endmodule

// File: tb/clkchan_regbank_test.sv
module clkchan_regbank_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wen = 1'b0;
  logic [7:0] bus_addr = 8'h30;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [4:0] sw_done = '0;
  logic [4:0] ch_en;
  logic [24:0] ch_src;
  logic [14:0] ch_pres;
  logic rdy_ch0, rdy_rest;
  int tests = 0, fails = 0;
  bit done_flag = 1'b0;

  always #5 clk = ~clk;

  clkchan_regbank uut (.clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sw_done(sw_done), .ch_en(ch_en),
    .ch_src(ch_src), .ch_pres(ch_pres), .rdy_ch0(rdy_ch0), .rdy_rest(rdy_rest));

  // {req, wen, addr, wdata, done, expected control read, expected status read}
  localparam int NV = 16;
  localparam logic [113:0] VEC [NV] = '{
    {4'd2,  1'b1, 8'h30, 32'h00000002, 5'h00, 32'h00000002, 32'h3}, // R2 select ch2
    {4'd3,  1'b1, 8'h30, 32'h10030582, 5'h00, 32'h10030502, 32'h1}, // R3 commit ch2, source changes
    {4'd5,  1'b0, 8'h30, 32'h00000000, 5'h04, 32'h10030502, 32'h3}, // R5 done ch2
    {4'd2,  1'b1, 8'h30, 32'h00000000, 5'h00, 32'h00000000, 32'h3}, // R2 select ch0
    {4'd6,  1'b1, 8'h30, 32'h10000280, 5'h00, 32'h10000200, 32'h3}, // R6 same source keeps ready
    {4'd5,  1'b1, 8'h30, 32'h10070280, 5'h00, 32'h10070200, 32'h2}, // R5 ch0 switch
    {4'd4,  1'b1, 8'h30, 32'h00000080, 5'h00, 32'h00070200, 32'h2}, // R4 disable keeps fields
    {4'd5,  1'b0, 8'h30, 32'h00000000, 5'h01, 32'h00070200, 32'h3}, // R5 done ch0
    {4'd8,  1'b1, 8'h30, 32'h00000006, 5'h00, 32'h00000006, 32'h3}, // R8 select index 6
    {4'd8,  1'b1, 8'h30, 32'h101F0786, 5'h00, 32'h00000006, 32'h3}, // R8 commit index 6
    {4'd8,  1'b1, 8'h30, 32'h00000002, 5'h00, 32'h10030502, 32'h3}, // R8 ch2 untouched
    {4'd9,  1'b1, 8'h40, 32'h10090782, 5'h00, 32'h10030502, 32'h3}, // R9 other offset
    {4'd7,  1'b1, 8'h30, 32'h10010084, 5'h00, 32'h10010004, 32'h1}, // R7 ch4 uses shared bit
    {4'd7,  1'b1, 8'h30, 32'h10020083, 5'h10, 32'h10020003, 32'h1}, // R7 ch3 arms while ch4 done
    {4'd10, 1'b1, 8'h30, 32'h10040083, 5'h08, 32'h10040003, 32'h1}, // R10 arm beats done
    {4'd10, 1'b0, 8'h30, 32'h00000000, 5'h08, 32'h10040003, 32'h3}  // R10 done ch3
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    rd(8'h30, d); check("R1 ctrl", d, 32'h0);
    rd(8'h34, d); check("R1 status", d, 32'h3);
    check("R1 ports", {7'b0, ch_en, ch_src, ch_pres}, 52'h0);
    check("R1 ready", {30'b0, rdy_rest, rdy_ch0}, 32'h3);

    for (int k = 0; k < NV; k++) begin
      logic [113:0] v;
      v = VEC[k];
      @(negedge clk);
      bus_wen = v[109]; bus_addr = v[108:101]; bus_wdata = v[100:69]; sw_done = v[68:64];
      @(posedge clk);
      #1 bus_wen = 1'b0; sw_done = '0;
      rd(8'h30, d); check($sformatf("R%0d ctrl step %0d", v[113:110], k), d, v[63:32]);
      rd(8'h34, d); check($sformatf("R%0d status step %0d", v[113:110], k), d, v[31:0]);
      check($sformatf("R%0d ready pins step %0d", v[113:110], k),
            {30'b0, rdy_rest, rdy_ch0}, v[31:0]);
    end

    // R3 setting outputs at the ports
    check("R3 ch_en", {27'b0, ch_en}, 32'h1C);
    check("R3 ch2 src", {27'b0, ch_src[14:10]}, 32'h3);
    check("R3 ch2 pres", {29'b0, ch_pres[8:6]}, 32'h5);
    check("R4 ch0 src kept", {27'b0, ch_src[4:0]}, 32'h7);

    // R9 commit data with wen low
    @(negedge clk);
    bus_wen = 1'b0; bus_addr = 8'h30; bus_wdata = 32'h101F0782;
    @(posedge clk); #1;
    rd(8'h30, d); check("R9 wen low ignored", d, 32'h10040003);
    check("R9 ch2 src kept", {27'b0, ch_src[14:10]}, 32'h3);
    rd(8'h44, d); check("R9 unmapped read", d, 32'h0);
    rd(8'h00, d); check("R9 unmapped read 0", d, 32'h0);

    // R1 reset again after activity
    @(negedge clk) rst_n = 1'b0;
    @(posedge clk); #1;
    rst_n = 1'b1;
    rd(8'h30, d); check("R1 ctrl after reset", d, 32'h0);
    check("R1 ports after reset", {7'b0, ch_en, ch_src, ch_pres}, 52'h0);
    done_flag = 1'b1;
  end

  initial begin
    fork
      wait (done_flag);
      begin
        repeat (5000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule